// File: doc/BRIEF.md
# Multiprocessor-Filter Asynchronous Serial Port

A full-duplex asynchronous serial port with two frame formats. The variable-rate format carries a start bit, eight data bits sent least significant first and a stop bit; its timing comes from external sample-tick inputs, with separate ticks for the transmit and receive sides. The fixed-rate format adds a programmable ninth bit between the data and the stop bit, and its timing is derived internally from the core clock: one bit every 64 clock cycles, or every 32 when the rate-doubling input is set.

The host writes a byte to send and reads the last byte received. A transmit-ninth-bit input supplies the extra bit of the fixed-rate format. A received-ninth-bit output returns that bit, or the stop bit in the variable-rate format. Two sticky flags tell the host that a stop bit has started on the line and that a frame has been accepted. The multiprocessor filter lets a receiver ignore every frame whose ninth bit is 0. That bit is normally used to mark address frames, so the filter lets a station listen only for addresses. Reception oversamples each bit 16 times, re-checks the start bit at mid-bit and takes each data bit by a vote of three samples.

Top module: `mpuart_core`

## Requirements
- R1: After reset the line output `txd` is 1, both flags are 0, and `buf_rdata` and `rx_ninth` are 0.
- R2: With `mode_sel` = 2'b01 a written byte goes out as one 0 start bit, then the eight data bits with bit 0 first, then one 1 stop bit. The start bit begins at the next bit boundary of a free-running bit counter, no more than one bit period plus one cycle after the write.
- R3: With `mode_sel` = 2'b10 the frame is a start bit, eight data bits with bit 0 first, then the value `tx_ninth` had at the write, then a 1 stop bit.
- R4: With `mode_sel` = 2'b10 one bit lasts 64 clock cycles, or 32 when `dbl_rate` is 1. With `mode_sel` = 2'b01 one bit lasts 16 pulses of `tx_rate_tick` on transmit and 16 pulses of `rx_rate_tick` on receive.
- R5: `tx_flag` rises on the clock edge that puts the stop bit on `txd`. It is 0 during the data bits of a frame that started with the flag clear, and it stays at 1 until `tx_flag_clr` is pulsed.
- R6: A buffer write is ignored, and changes neither the current frame nor the line afterwards, while a frame is waiting or before its stop bit, and whenever `mode_sel` is 2'b00 or 2'b11.
- R7: Reception starts on a 1-to-0 change of the sampled `rxd`. If the line is high again at the middle of the start bit, reception is abandoned and the receiver waits for a new falling edge.
- R8: Each data bit and the ninth bit take the majority of three samples at sample ticks 7, 8 and 9 of the bit, so a glitch lasting four clock cycles in the fixed-rate format does not change the data.
- R9: A frame is accepted only if `rx_flag` is 0 and either `mp_filter` is 0 or the ninth bit (the stop bit in the variable-rate format) is 1. Otherwise the frame is dropped, with `rx_flag`, `buf_rdata` and `rx_ninth` left unchanged.
- R10: On acceptance `buf_rdata` takes the eight data bits, `rx_ninth` takes the ninth or stop bit and `rx_flag` rises. The flag stays at 1 until `rx_flag_clr` is pulsed.
- R11: No frame is received while `rx_en` is 0 or while `mode_sel` is 2'b00 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 2'b01 variable-rate 10-bit frame, 2'b10 fixed-rate 11-bit frame, other values disable the port |
| dbl_rate | input | 1 | Halves the fixed-rate bit period |
| tx_rate_tick | input | 1 | Transmit sample tick in the variable-rate format (16 per bit) |
| rx_rate_tick | input | 1 | Receive sample tick in the variable-rate format (16 per bit) |
| buf_wr | input | 1 | One-cycle strobe that starts a transmission |
| buf_wdata | input | DATA_W | Byte to transmit |
| tx_ninth | input | 1 | Ninth bit to send in the 11-bit frame |
| rx_en | input | 1 | Receive enable |
| mp_filter | input | 1 | Drop frames whose ninth or stop bit is 0 |
| tx_flag_clr | input | 1 | Clears `tx_flag` |
| rx_flag_clr | input | 1 | Clears `rx_flag` |
| rxd | input | 1 | Serial receive line |
| buf_rdata | output | DATA_W | Last accepted byte |
| rx_ninth | output | 1 | Ninth or stop bit of the last accepted frame |
| tx_flag | output | 1 | Stop bit has started on the line |
| rx_flag | output | 1 | A frame has been accepted |
| txd | output | 1 | Serial transmit line |

## Verification
After a write, the start bit appears within one bit period plus one cycle. Each later bit follows exactly one bit period after the one before it, and `tx_flag` rises on the edge that starts the stop bit. The bench therefore finds the falling edge of `txd`, moves half a bit to the middle of the start bit, and then checks every bit, and the flag, one bit period apart. On receive, the input passes a two-stage synchronizer and the sample-tick grid, so acceptance falls at about sample 9 of the last captured bit, well before that bit ends. The receive results are checked a few cycles after the whole frame, including its stop bit, has been driven. Glitches and false starts are placed by clock count from the start of the bit the bench drives, so that, whatever the phase of the tick grid, they fall on the samples they are meant to hit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

   typedef enum logic [1:0] {
      PM_OFF_LO = 2'b00,
      PM_VAR10  = 2'b01,
      PM_FIX11  = 2'b10,
      PM_OFF_HI = 2'b11
   } port_mode_e;

   function automatic logic mode_is_live(input logic [1:0] m);
      return (m == PM_VAR10) || (m == PM_FIX11);
   endfunction

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/mpuart_rate.sv
module mpuart_rate #(
   parameter int OVS         = 16,
   parameter int FIX_DIV     = 64,
   parameter bit SPLIT_TICKS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fixed_mode,
   input  logic dbl,
   input  logic tx_tick_in,
   input  logic rx_tick_in,
   output logic tx_stk,
   output logic rx_stk
);
   localparam int PER = FIX_DIV / OVS;
   localparam int DW  = (PER > 2) ? $clog2(PER) : 1;

   logic [DW-1:0] div_q;
   logic [DW-1:0] lim;
   logic          fix_stk;

   assign lim     = dbl ? DW'(PER / 2 - 1) : DW'(PER - 1);
   assign fix_stk = (div_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (fix_stk) div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   assign tx_stk = fixed_mode ? fix_stk : tx_tick_in;

   generate
      if (SPLIT_TICKS) begin : g_split
         assign rx_stk = fixed_mode ? fix_stk : rx_tick_in;
      end else begin : g_shared
         assign rx_stk = tx_stk;
      end
   endgenerate

endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stk,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ninth_in,
   input  logic              nine,
   input  logic              mode_ok,
   output logic              txd,
   output logic              stop_set
);
   localparam int PH_W  = $clog2(OVS);
   localparam int CNT_W = $clog2(DATA_W + 3);
   localparam int SH_W  = DATA_W + 2;

   logic [PH_W-1:0]  ph;
   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             pend;
   logic             nine_q;
   logic             txd_q;
   logic             bnd;
   logic             take_wr;

   assign bnd     = stk && (ph == PH_W'(OVS - 1));
   assign take_wr = wr && mode_ok && !pend && (!run || (cnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph     <= '0;
         sh     <= '1;
         cnt    <= '0;
         run    <= 1'b0;
         pend   <= 1'b0;
         nine_q <= 1'b0;
         txd_q  <= 1'b1;
      end else begin
         if (stk) ph <= ph + 1'b1;
         if (take_wr) begin
            sh     <= {1'b1, (nine ? ninth_in : 1'b1), wdata};
            nine_q <= nine;
            pend   <= 1'b1;
         end
         if (bnd) begin
            if (run && (cnt != '0)) begin
               txd_q <= sh[0];
               sh    <= {1'b1, sh[SH_W-1:1]};
               cnt   <= cnt - 1'b1;
            end else if (pend) begin
               txd_q <= 1'b0;
               run   <= 1'b1;
               cnt   <= nine_q ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
               pend  <= 1'b0;
            end else begin
               run <= 1'b0;
            end
         end
      end
   end

   assign stop_set = bnd && run && (cnt == CNT_W'(1));
   assign txd      = txd_q;

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter bit MAJ3   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stk,
   input  logic              rxd_s,
   input  logic              en,
   input  logic              flag_now,
   input  logic              filt,
   output logic              acc,
   output logic [DATA_W-1:0] acc_data,
   output logic              acc_ninth
);
   localparam int PH_W = $clog2(OVS);
   localparam int MID  = OVS / 2;
   localparam int LAST = DATA_W + 1;
   localparam int BI_W = $clog2(DATA_W + 2);

   logic              act;
   logic              prev;
   logic [PH_W-1:0]   sc;
   logic [BI_W-1:0]   bi;
   logic              s_a;
   logic              s_b;
   logic [DATA_W-1:0] shd;
   logic              bitv;
   logic              at_a;
   logic              at_b;
   logic              at_d;
   logic              last_shift;

   assign at_a = (sc == PH_W'(MID - 1));
   assign at_b = (sc == PH_W'(MID));
   assign at_d = (sc == PH_W'(MID + 1));

   generate
      if (MAJ3) begin : g_vote
         assign bitv = vote3(s_a, s_b, rxd_s);
      end else begin : g_single
         assign bitv = s_b;
      end
   endgenerate

   assign last_shift = stk && act && en && at_d && (bi == BI_W'(LAST));
   assign acc        = last_shift && !flag_now && (!filt || bitv);
   assign acc_data   = shd;
   assign acc_ninth  = bitv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         prev <= 1'b1;
         sc   <= '0;
         bi   <= '0;
         s_a  <= 1'b1;
         s_b  <= 1'b1;
         shd  <= '0;
      end else if (stk) begin
         prev <= rxd_s;
         if (!act) begin
            if (en && prev && !rxd_s) begin
               act <= 1'b1;
               sc  <= PH_W'(1);
               bi  <= '0;
            end
         end else if (!en) begin
            act <= 1'b0;
         end else begin
            if (sc == PH_W'(OVS - 1)) begin
               sc <= '0;
               bi <= bi + 1'b1;
            end else begin
               sc <= sc + 1'b1;
            end
            if (at_a) s_a <= rxd_s;
            if (at_b) s_b <= rxd_s;
            if ((bi == '0) && at_b && rxd_s) act <= 1'b0;
            if (at_d && (bi != '0)) begin
               if (bi <= BI_W'(DATA_W)) shd <= {bitv, shd[DATA_W-1:1]};
               if (bi == BI_W'(LAST))   act <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/mpuart_core.sv
module mpuart_core
   import mpuart_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int FIX_DIV     = 64,
   parameter bit SPLIT_TICKS = 1'b1,
   parameter bit MAJ3        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              dbl_rate,
   input  logic              tx_rate_tick,
   input  logic              rx_rate_tick,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              tx_ninth,
   input  logic              rx_en,
   input  logic              mp_filter,
   input  logic              tx_flag_clr,
   input  logic              rx_flag_clr,
   input  logic              rxd,
   output logic [DATA_W-1:0] buf_rdata,
   output logic              rx_ninth,
   output logic              tx_flag,
   output logic              rx_flag,
   output logic              txd
);
   initial begin
      assert (OVS >= 8 && (OVS & (OVS - 1)) == 0)
         else $error("mpuart_core: OVS must be a power of two of at least 8");
      assert (FIX_DIV % (2 * OVS) == 0)
         else $error("mpuart_core: FIX_DIV must be a multiple of 2*OVS");
      assert (DATA_W >= 5)
         else $error("mpuart_core: DATA_W must be at least 5");
   end

   logic              mode_ok;
   logic              fixed_mode;
   logic              rx_s1, rx_s2;
   logic              tx_stk, rx_stk;
   logic              stop_set;
   logic              acc;
   logic [DATA_W-1:0] acc_data;
   logic              acc_ninth;
   logic              tx_flag_q, rx_flag_q;
   logic [DATA_W-1:0] rbuf_q;
   logic              rninth_q;

   assign mode_ok    = mode_is_live(mode_sel);
   assign fixed_mode = (mode_sel == PM_FIX11);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_s1 <= 1'b1;
         rx_s2 <= 1'b1;
      end else begin
         rx_s1 <= rxd;
         rx_s2 <= rx_s1;
      end
   end

   mpuart_rate #(
      .OVS(OVS), .FIX_DIV(FIX_DIV), .SPLIT_TICKS(SPLIT_TICKS)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .fixed_mode(fixed_mode), .dbl(dbl_rate),
      .tx_tick_in(tx_rate_tick), .rx_tick_in(rx_rate_tick),
      .tx_stk(tx_stk), .rx_stk(rx_stk)
   );

   mpuart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .stk(tx_stk), .wr(buf_wr), .wdata(buf_wdata),
      .ninth_in(tx_ninth), .nine(fixed_mode), .mode_ok(mode_ok),
      .txd(txd), .stop_set(stop_set)
   );

   mpuart_rx #(.DATA_W(DATA_W), .OVS(OVS), .MAJ3(MAJ3)) u_rx (
      .clk(clk), .rst_n(rst_n), .stk(rx_stk), .rxd_s(rx_s2),
      .en(rx_en && mode_ok), .flag_now(rx_flag_q), .filt(mp_filter),
      .acc(acc), .acc_data(acc_data), .acc_ninth(acc_ninth)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_flag_q <= 1'b0;
         rx_flag_q <= 1'b0;
         rbuf_q    <= '0;
         rninth_q  <= 1'b0;
      end else begin
         if (stop_set)         tx_flag_q <= 1'b1;
         else if (tx_flag_clr) tx_flag_q <= 1'b0;
         if (acc) begin
            rx_flag_q <= 1'b1;
            rbuf_q    <= acc_data;
            rninth_q  <= acc_ninth;
         end else if (rx_flag_clr) begin
            rx_flag_q <= 1'b0;
         end
      end
   end

   assign tx_flag   = tx_flag_q;
   assign rx_flag   = rx_flag_q;
   assign buf_rdata = rbuf_q;
   assign rx_ninth  = rninth_q;

endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_flag,
   input logic              tx_flag_clr,
   input logic              rx_flag,
   input logic              rx_flag_clr,
   input logic [DATA_W-1:0] buf_rdata,
   input logic              rx_ninth,
   input logic              txd
);
   AST_TXFLAG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_flag) |-> txd); // R5
   AST_TXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag && !tx_flag_clr) |=> tx_flag); // R5
   AST_RXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !rx_flag_clr) |=> rx_flag); // R10
   AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flag |=> $stable(buf_rdata)); // R9
   AST_NINTH_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(rx_flag) |-> $stable(rx_ninth)); // R10
   AST_DATA_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(rx_flag) |-> $stable(buf_rdata)); // R9
endmodule

bind mpuart_core mpuart_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_flag(tx_flag), .tx_flag_clr(tx_flag_clr),
   .rx_flag(rx_flag), .rx_flag_clr(rx_flag_clr), .buf_rdata(buf_rdata),
   .rx_ninth(rx_ninth), .txd(txd)
);

// File: tb/tb_mpuart_core.sv
module tb_mpuart_core;
   localparam int FIX_BIT = 64;
   localparam int DBL_BIT = 32;
   localparam int VAR_PER = 3;
   localparam int VAR_BIT = 16 * VAR_PER;
   localparam int WD_CYC  = 150000;

   // {nine, filter, ninth/stop, data[7:0], expect_accept}
   localparam logic [11:0] VEC [8] = '{
      {1'b1, 1'b0, 1'b0, 8'hA5, 1'b1},
      {1'b1, 1'b0, 1'b1, 8'h3C, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h77, 1'b0},
      {1'b1, 1'b1, 1'b1, 8'hC1, 1'b1},
      {1'b0, 1'b0, 1'b1, 8'h5A, 1'b1},
      {1'b0, 1'b1, 1'b1, 8'h80, 1'b1},
      {1'b0, 1'b1, 1'b0, 8'h01, 1'b0},
      {1'b0, 1'b0, 1'b0, 8'hFF, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_sel;
   logic       dbl_rate;
   logic       var_tick;
   logic       buf_wr;
   logic [7:0] buf_wdata;
   logic       tx_ninth;
   logic       rx_en;
   logic       mp_filter;
   logic       tx_flag_clr;
   logic       rx_flag_clr;
   logic       rxd;
   logic [7:0] buf_rdata;
   logic       rx_ninth;
   logic       tx_flag;
   logic       rx_flag;
   logic       txd;

   int errors = 0;
   int checks = 0;
   logic [7:0] last_rx;

   always #4 clk = ~clk;

   mpuart_core dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dbl_rate(dbl_rate),
      .tx_rate_tick(var_tick), .rx_rate_tick(var_tick), .buf_wr(buf_wr),
      .buf_wdata(buf_wdata), .tx_ninth(tx_ninth), .rx_en(rx_en),
      .mp_filter(mp_filter), .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
      .rxd(rxd), .buf_rdata(buf_rdata), .rx_ninth(rx_ninth), .tx_flag(tx_flag),
      .rx_flag(rx_flag), .txd(txd)
   );

   initial begin
      var_tick = 1'b0;
      forever begin
         repeat (VAR_PER - 1) @(negedge clk);
         var_tick = 1'b1;
         @(negedge clk);
         var_tick = 1'b0;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_tx(input logic [7:0] d, input logic b9);
      buf_wdata = d;
      tx_ninth  = b9;
      buf_wr    = 1'b1;
      tick(1);
      buf_wr    = 1'b0;
   endtask

   task automatic clear_tx_flag();
      tx_flag_clr = 1'b1;
      tick(1);
      tx_flag_clr = 1'b0;
   endtask

   task automatic clear_rx_flag();
      rx_flag_clr = 1'b1;
      tick(1);
      rx_flag_clr = 1'b0;
   endtask

   // Called right after the write; checks every bit at its middle.
   task automatic tx_check(input logic [7:0] d, input logic b9, input bit nine,
                           input int bw, input string tag, input bit inject);
      int n;
      n = 0;
      while (txd !== 1'b0 && n < 4 * bw) begin
         tick(1);
         n++;
      end
      chk_eq({tag, " R2 start latency ok"}, int'(n <= bw + 1), 1);
      tick(bw / 2);
      chk_eq({tag, " R2 start bit"}, txd, 0);
      for (int i = 0; i < 8; i++) begin
         if (inject && i == 2) begin
            send_tx(~d, ~b9);
            tick(bw - 1);
         end else begin
            tick(bw);
         end
         chk_eq({tag, " R2 data bit"}, txd, d[i]);
      end
      chk_eq({tag, " R5 flag low before stop"}, tx_flag, 0);
      if (nine) begin
         tick(bw);
         chk_eq({tag, " R3 ninth bit"}, txd, b9);
      end
      tick(bw);
      chk_eq({tag, " R2 stop bit"}, txd, 1);
      chk_eq({tag, " R5 flag at stop"}, tx_flag, 1);
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic b9, input bit nine,
                           input int bw, input bit glitch);
      rxd = 1'b1;
      tick(bw / 4);
      rxd = 1'b0;
      tick(bw);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i];
         if (glitch) begin
            tick(29 + i);
            rxd = ~d[i];
            tick(4);
            rxd = d[i];
            tick(bw - 33 - i);
         end else begin
            tick(bw);
         end
      end
      rxd = b9;
      tick(bw);
      if (nine) begin
         rxd = 1'b1;
         tick(bw);
      end
      rxd = 1'b1;
      tick(8);
   endtask

   task automatic watch_idle(input int n, input string tag);
      int lows;
      lows = 0;
      for (int k = 0; k < n; k++) begin
         tick(1);
         if (txd !== 1'b1) lows++;
      end
      chk_eq({tag, " R6 line stays idle"}, lows, 0);
   endtask

   initial begin
      logic [11:0] e;
      rst_n = 1'b0; mode_sel = 2'b10; dbl_rate = 1'b0; buf_wr = 1'b0;
      buf_wdata = '0; tx_ninth = 1'b0; rx_en = 1'b1; mp_filter = 1'b0;
      tx_flag_clr = 1'b0; rx_flag_clr = 1'b0; rxd = 1'b1;
      last_rx = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(2);

      chk_eq("R1 txd idle", txd, 1);
      chk_eq("R1 tx_flag", tx_flag, 0);
      chk_eq("R1 rx_flag", rx_flag, 0);
      chk_eq("R1 buf_rdata", buf_rdata, 0);
      chk_eq("R1 rx_ninth", rx_ninth, 0);

      // Vector walk: transmit then receive each entry.
      for (int v = 0; v < 8; v++) begin
         e = VEC[v];
         mode_sel  = e[11] ? 2'b10 : 2'b01;
         mp_filter = e[10];
         tick(2);
         send_tx(e[8:1], e[9]);
         tx_check(e[8:1], e[9], e[11], e[11] ? FIX_BIT : VAR_BIT,
                  e[11] ? "R3 R4 vec fixed" : "R2 R4 vec var", 1'b0);
         clear_tx_flag();
         chk_eq("R5 tx_flag cleared", tx_flag, 0);
         tick(e[11] ? FIX_BIT : VAR_BIT);
         rx_frame(e[8:1], e[9], e[11], e[11] ? FIX_BIT : VAR_BIT, 1'b0);
         chk_eq("R9 accept decision", rx_flag, e[0]);
         if (e[0]) begin
            chk_eq("R10 data latched", buf_rdata, e[8:1]);
            chk_eq("R10 ninth latched", rx_ninth, e[9]);
            last_rx = e[8:1];
         end else begin
            chk_eq("R9 dropped frame leaves buffer", buf_rdata, last_rx);
         end
         clear_rx_flag();
         chk_eq("R10 rx_flag cleared", rx_flag, 0);
      end
      mp_filter = 1'b0;

      // Doubled fixed rate.
      mode_sel = 2'b10;
      dbl_rate = 1'b1;
      tick(2);
      send_tx(8'h96, 1'b1);
      tx_check(8'h96, 1'b1, 1'b1, DBL_BIT, "R4 doubled", 1'b0);
      clear_tx_flag();
      tick(DBL_BIT);
      rx_frame(8'h69, 1'b0, 1'b1, DBL_BIT, 1'b0);
      chk_eq("R4 doubled rx data", buf_rdata, 8'h69);
      last_rx = 8'h69;
      clear_rx_flag();
      dbl_rate = 1'b0;
      tick(8);

      // Write during a frame is ignored.
      send_tx(8'hA3, 1'b0);
      tx_check(8'hA3, 1'b0, 1'b1, FIX_BIT, "R6 busy write", 1'b1);
      clear_tx_flag();
      watch_idle(3 * FIX_BIT, "R6 busy write");

      // Write in a disabled mode is ignored.
      mode_sel = 2'b00;
      tick(2);
      send_tx(8'h00, 1'b0);
      watch_idle(4 * FIX_BIT, "R6 disabled mode");
      chk_eq("R6 disabled mode tx_flag", tx_flag, 0);

      // Receive in a disabled mode.
      rx_frame(8'h42, 1'b1, 1'b1, FIX_BIT, 1'b0);
      chk_eq("R11 disabled mode rx_flag", rx_flag, 0);
      chk_eq("R11 disabled mode buffer", buf_rdata, last_rx);

      // Receive with rx_en low.
      mode_sel = 2'b10;
      rx_en = 1'b0;
      tick(2);
      rx_frame(8'h24, 1'b1, 1'b1, FIX_BIT, 1'b0);
      chk_eq("R11 rx_en low rx_flag", rx_flag, 0);
      chk_eq("R11 rx_en low buffer", buf_rdata, last_rx);
      rx_en = 1'b1;
      tick(2);

      // Flag still set: second frame dropped.
      rx_frame(8'h11, 1'b0, 1'b1, FIX_BIT, 1'b0);
      chk_eq("R10 first frame", buf_rdata, 8'h11);
      rx_frame(8'h22, 1'b1, 1'b1, FIX_BIT, 1'b0);
      chk_eq("R9 flag set keeps data", buf_rdata, 8'h11);
      chk_eq("R9 flag set keeps ninth", rx_ninth, 0);
      chk_eq("R9 flag still set", rx_flag, 1);
      clear_rx_flag();
      last_rx = 8'h11;

      // False start.
      rxd = 1'b0;
      tick(12);
      rxd = 1'b1;
      tick(11 * FIX_BIT);
      chk_eq("R7 false start no flag", rx_flag, 0);
      chk_eq("R7 false start buffer", buf_rdata, last_rx);
      rx_frame(8'h3E, 1'b1, 1'b1, FIX_BIT, 1'b0);
      chk_eq("R7 frame after false start", buf_rdata, 8'h3E);
      clear_rx_flag();

      // Four-cycle glitches inside each data bit.
      rx_frame(8'hB4, 1'b1, 1'b1, FIX_BIT, 1'b1);
      chk_eq("R8 glitch data", buf_rdata, 8'hB4);
      chk_eq("R8 glitch flag", rx_flag, 1);
      clear_rx_flag();
      rx_frame(8'h4B, 1'b0, 1'b1, FIX_BIT, 1'b1);
      chk_eq("R8 glitch data inverted", buf_rdata, 8'h4B);
      clear_rx_flag();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule